// File: doc/BRIEF.md
# Dual-Issue Pairing Gate for Multiply-Unit Instructions

The block sits between decode and issue in an in-order pipeline that can issue two instructions per slot. Each cycle it sees an older and a younger decoded instruction, each as a 4-bit class code with a valid bit. It looks up which shared resources each class needs and decides whether the pair may issue together. The shared resources are the memory-access pipeline, the multiplier, and the path that reads the multiply result registers. For the multiplier, the table records both whether a class uses it and whether the class locks it.

On a conflict the older instruction issues alone and the younger one is held for exactly one slot. In the next cycle it issues alone, and the block ignores what is on its inputs in that cycle. A 2-bit reason code tells which resource caused the conflict. Because multiplier use and multiplier lock are kept apart, a store of a multiply result register to memory can issue alongside a new multiply.

Top module: `pair_issue_gate`

## Requirements
- R1: The class codes are: 0 no-op, 1 ALU, 2 generic load/store, 3 to 8 multiply-start classes (16-bit signed, 16-bit unsigned, 32x32 signed double, 32x32 unsigned double, 32-bit, multiply-to-register), 9 store-multiply-register-to-general-register, 10 store-multiply-register-to-memory, 11 load-multiply-register-from-register, 12 load-multiply-register-from-memory. Codes 13 to 15 use no resource.
- R2: Resources by class: 2 uses the memory pipe. 3 to 8 and 11 use and lock the multiplier. 9 uses the read path. 10 uses the memory pipe and the read path, and uses the multiplier without locking it. 12 uses the memory pipe and uses and locks the multiplier. Classes 0, 1 and 13 to 15 use nothing.
- R3: When both valid instructions use the result read path, `stall_o`=1, `pair_o`=0 and `reason_o`=2. The read-path reason takes priority over all others.
- R4: When both use the memory pipe and there is no read-path clash, `stall_o`=1 and `reason_o`=1.
- R5: When the older instruction locks the multiplier, the younger one uses it, and there is no other clash, `stall_o`=1 and `reason_o`=3.
- R6: A store-multiply-register-to-memory followed by any multiply-start class, or by a load-multiply-register-from-register, gives `pair_o`=1 and `stall_o`=0.
- R7: Any pair without a clash gives `pair_o`=1 and `reason_o`=0.
- R8: The cycle after a stall, `hold_o`=1 and `held_cls_o` equals the held younger class. In that cycle `pair_o`, `stall_o` and `reason_o` are 0 whatever the inputs are.
- R9: A hold lasts exactly one cycle. In the cycle after it, pairing is decided normally again.
- R10: With fewer than two valid instructions, `pair_o`, `stall_o` and `reason_o` are 0.
- R11: A synchronous active-high reset clears any pending hold. While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| old_vld | input | 1 | Older instruction valid |
| old_cls | input | 4 | Older instruction class |
| yng_vld | input | 1 | Younger instruction valid |
| yng_cls | input | 4 | Younger instruction class |
| pair_o | output | 1 | Both instructions issue this slot |
| stall_o | output | 1 | Older issues alone; younger held one slot |
| hold_o | output | 1 | Held younger issues alone; inputs ignored |
| reason_o | output | 2 | 0 none, 1 memory pipe, 2 read path, 3 multiplier lock |
| held_cls_o | output | 4 | Class of the instruction issuing from hold |

## Verification
A store-to-memory followed by another store-to-memory clashes on both the memory pipe and the read path. A design with the wrong priority would report the memory-pipe reason there. Every multiply-start class is paired behind a store-to-memory, so a design that merges "uses" with "locks" would stall those pairs. The hold cycle is driven with a conflicting pair on the inputs; a design that did not ignore them would raise a second stall or pair. The bench also drives an assertion of reset while a hold is pending, and a design whose hold outlives reset would show `hold_o` afterwards.

// File: rtl/pair_issue_gate.sv
module pair_issue_gate #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          old_vld,
  input  logic [CW-1:0] old_cls,
  input  logic          yng_vld,
  input  logic [CW-1:0] yng_cls,
  output logic          pair_o,
  output logic          stall_o,
  output logic          hold_o,
  output logic [1:0]    reason_o,
  output logic [CW-1:0] held_cls_o
);

  // resource vector bits: 0 mem pipe, 1 mul use, 2 mul lock, 3 read path
  function automatic logic [3:0] res_of(input logic [CW-1:0] c);
    case (int'(c))
      2:                   return 4'b0001;
      3, 4, 5, 6, 7, 8:    return 4'b0110;
      9:                   return 4'b1000;
      10:                  return 4'b1011;
      11:                  return 4'b0110;
      12:                  return 4'b0111;
      default:             return 4'b0000;
    endcase
  endfunction

  logic [3:0]    r_old, r_yng;
  logic          both, c_mem, c_rd, c_lk, conf;
  logic [1:0]    why;
  logic          hold_q;
  logic [CW-1:0] cls_q;

  assign r_old = res_of(old_cls);
  assign r_yng = res_of(yng_cls);
  assign both  = old_vld && yng_vld && !hold_q && !rst;

  assign c_mem = r_old[0] && r_yng[0];
  assign c_rd  = r_old[3] && r_yng[3];
  assign c_lk  = r_old[2] && r_yng[1];
  assign conf  = c_mem || c_rd || c_lk;

  always_comb begin
    if (c_rd)       why = 2'd2;
    else if (c_mem) why = 2'd1;
    else if (c_lk)  why = 2'd3;
    else            why = 2'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      cls_q  <= '0;
    end else begin
      hold_q <= both && conf;
      if (both && conf) cls_q <= yng_cls;
    end
  end

  assign pair_o     = both && !conf;
  assign stall_o    = both && conf;
  assign reason_o   = stall_o ? why : 2'd0;
  assign hold_o     = hold_q && !rst;
  assign held_cls_o = hold_o ? cls_q : '0;

  // R8
  stall_to_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> hold_o && held_cls_o == $past(yng_cls));

  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    hold_o |-> !pair_o && !stall_o && reason_o == 2'd0);

  // R9
  hold_once_chk: assert property (@(posedge clk) disable iff (rst)
    hold_o |=> !hold_o);

  // R10
  single_alone_chk: assert property (@(posedge clk) disable iff (rst)
    !(old_vld && yng_vld) |-> !pair_o && !stall_o && reason_o == 2'd0);

  // R3
  read_clash_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold_o && old_vld && yng_vld && old_cls == CW'(10) && yng_cls == CW'(10))
      |-> stall_o && reason_o == 2'd2);

  // R7
  pair_no_reason_chk: assert property (@(posedge clk) disable iff (rst)
    pair_o |-> reason_o == 2'd0 && !$onehot0({pair_o, stall_o, hold_o}) == 1'b0);

endmodule

// File: tb/sim_pair_issue_gate.sv
module sim_pair_issue_gate;
  logic clk = 0, rst = 1;
  logic ov = 0, yv = 0;
  logic [3:0] oc = 0, yc = 0;
  logic pair, stall, hold;
  logic [1:0] why;
  logic [3:0] hcls;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pair_issue_gate u0 (.clk(clk), .rst(rst), .old_vld(ov), .old_cls(oc),
    .yng_vld(yv), .yng_cls(yc), .pair_o(pair), .stall_o(stall),
    .hold_o(hold), .reason_o(why), .held_cls_o(hcls));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(bit a, int ac, bit b, int bc);
    @(negedge clk);
    ov = a; oc = 4'(ac); yv = b; yc = 4'(bc);
    #5;
  endtask

  task automatic expect_out(string req, int p, int s, int h, int r);
    chk({req, " pair"}, pair, p);
    chk({req, " stall"}, stall, s);
    chk({req, " hold"}, hold, h);
    chk({req, " reason"}, why, r);
  endtask

  task automatic t_reset_state();
    put(1, 10, 1, 10);
    expect_out("R11 in reset", 0, 0, 0, 0);
    chk("R11 held_cls", hcls, 0);
    @(negedge clk); rst = 0; ov = 0; yv = 0;
  endtask

  task automatic t_read_path();
    put(1, 10, 1, 10); expect_out("R3 stsl-stsl", 0, 1, 0, 2);
    put(0, 0, 0, 0);
    put(1, 10, 1, 9);  expect_out("R3 stsl-sts", 0, 1, 0, 2);
    put(0, 0, 0, 0);
  endtask

  task automatic t_mem_pipe();
    put(1, 10, 1, 12); expect_out("R4 stsl-ldsl", 0, 1, 0, 1);
    put(0, 0, 0, 0);
    put(1, 2, 1, 2);   expect_out("R4 ld-ld", 0, 1, 0, 1);
    put(0, 0, 0, 0);
  endtask

  task automatic t_lock();
    put(1, 7, 1, 10);  expect_out("R5 mul-stsl", 0, 1, 0, 3);
    put(0, 0, 0, 0);
    put(1, 3, 1, 8);   expect_out("R5 mul-mul", 0, 1, 0, 3);
    put(0, 0, 0, 0);
  endtask

  task automatic t_nonlock_pair();
    for (int c = 3; c <= 8; c++) begin
      put(1, 10, 1, c); expect_out($sformatf("R6 stsl-cls%0d", c), 1, 0, 0, 0);
    end
    put(1, 10, 1, 11); expect_out("R6 stsl-lds", 1, 0, 0, 0);
  endtask

  task automatic t_clean_pairs();
    put(1, 1, 1, 2);   expect_out("R7 R1 alu-ld", 1, 0, 0, 0);
    put(1, 9, 1, 12);  expect_out("R7 R2 sts-ldsl", 1, 0, 0, 0);
    put(1, 13, 1, 15); expect_out("R7 R1 unused", 1, 0, 0, 0);
    put(1, 10, 1, 2);  expect_out("R2 stsl-ld mem", 0, 1, 0, 1);
    put(0, 0, 0, 0);
  endtask

  task automatic t_single();
    put(1, 10, 0, 10); expect_out("R10 old only", 0, 0, 0, 0);
    put(0, 10, 1, 10); expect_out("R10 yng only", 0, 0, 0, 0);
  endtask

  task automatic t_hold_seq();
    put(1, 10, 1, 9);  expect_out("R8 stall", 0, 1, 0, 2);
    put(1, 7, 1, 7);   expect_out("R8 hold ignores inputs", 0, 0, 1, 0);
    chk("R8 held_cls", hcls, 9);
    put(1, 10, 1, 7);  expect_out("R9 normal after hold", 1, 0, 0, 0);
    put(1, 7, 1, 7);   expect_out("R9 stall again", 0, 1, 0, 3);
    put(1, 1, 1, 1);   expect_out("R9 hold", 0, 0, 1, 0);
    chk("R9 held_cls", hcls, 7);
    put(0, 0, 0, 0);   expect_out("R9 idle", 0, 0, 0, 0);
  endtask

  task automatic t_reset_clears();
    put(1, 2, 1, 2);   expect_out("R11 stall", 0, 1, 0, 1);
    @(negedge clk); rst = 1; ov = 0; yv = 0;
    @(negedge clk); rst = 0; #5;
    expect_out("R11 hold cleared", 0, 0, 0, 0);
  endtask

  initial begin
    t_reset_state();
    t_read_path();
    t_mem_pipe();
    t_lock();
    t_nonlock_pair();
    t_clean_pairs();
    t_single();
    t_hold_seq();
    t_reset_clears();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule